// File: doc/BRIEF.md
# Generation-Tagged Device Context Cache

This block holds recently fetched 128-bit device context entries, one per slot, keyed by a 16-bit requester ID: bus number in bits [15:8], device/function number in bits [7:0]. No slot has a valid bit. Each slot instead stores a generation stamp. The stamp counts as live only while it equals a shared generation counter. Because of this, invalidating every slot at once is a single counter increment rather than a clear of every entry.

A lookup returns hit or miss one cycle later, with the cached entry on a hit. On a miss, the table walker fetches the entry and writes it back through the fill port, stamped with the current generation. A global invalidation bumps the counter. When the counter reaches its all-ones value, a sweep clears one slot stamp per cycle and then restarts the counter at 1. While the sweep runs, `busy` is high and the block takes no requests. A device-selective invalidation zeroes the stamp of every slot on the named bus whose low device/function bits agree with the target under a 2-bit mask code.

Top module: `ctx_gen_cache`

## Requirements
- R1: After reset every slot stamp is 0 and the generation counter is 1, so every lookup misses; `busy`, `rsp_valid`, `rsp_hit` are 0 and `rsp_entry` is 0.
- R2: A lookup accepted in cycle N gives `rsp_valid`=1 in cycle N+1. `rsp_hit` is 1 only if a slot holds the same 16-bit ID and a stamp equal to the generation. On a miss `rsp_entry` is 0.
- R3: A fill with `fill_fault`=0 stores the entry and stamps it with the current generation, so a later lookup of that ID returns the entry. A fill with `fill_fault`=1 writes nothing.
- R4: A global invalidation increments the generation, so every entry filled before it misses afterwards.
- R5: If the increment makes the generation equal to 2^GEN_W-1, `busy` rises on the next cycle and stays high for exactly SLOTS cycles while one stamp is cleared per cycle. The generation then becomes 1, and all earlier entries miss.
- R6: A device-selective invalidation compares `inv_sid[15:8]` with the slot bus, and compares the slot devfn bits [2:0] with `inv_sid[2:0]` under a mask taken from `inv_fm`: 0 gives 000b, 1 gives 100b, 2 gives 110b, 3 gives 111b. Only the mask bits are compared and devfn bits [7:3] are not. Every slot that matches gets stamp 0.
- R7: While `busy` is 1, lookups produce no response, and fills and invalidations are ignored.
- R8: An invalidation and a lookup in the same cycle: the lookup sees the state after the invalidation. A fill in the same cycle as any invalidation is dropped.
- R9: A fill picks its slot in this order. First, the slot already holding that ID with a live stamp. Otherwise, the lowest-index slot with a stale stamp. If every slot is live, a round-robin victim that starts at slot 0 and advances by one per replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_sid | input | 16 | Lookup requester ID {bus, devfn} |
| fill_req | input | 1 | Fill request after a miss fetch |
| fill_fault | input | 1 | Fetch faulted; suppress the write |
| fill_sid | input | 16 | Fill requester ID |
| fill_entry | input | 128 | Fetched context entry |
| inv_glb | input | 1 | Global invalidation |
| inv_dev | input | 1 | Device-selective invalidation |
| inv_sid | input | 16 | Target requester ID for device invalidation |
| inv_fm | input | 2 | Function mask code |
| busy | output | 1 | Wrap sweep in progress; requests ignored |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_entry | output | 128 | Cached entry on hit, else 0 |

## Verification
The assertions assume that reset inputs are quiet and that no request is issued while `busy` is high except where the block must ignore it. In particular, they assume fills arrive only for IDs whose stamps the counter can reach. The generation can therefore never exceed the stamps by more than the counter range. The stimulus uses a 3-bit generation and four slots so that wrap, replacement and masked invalidation all occur within a short run. It raises requests during the sweep only to confirm that they are ignored.

// File: rtl/ctxc_pkg.sv
package ctxc_pkg;
  localparam int SID_W = 16;
  localparam int BUS_LSB = 8;

  typedef enum logic {
    GS_RUN   = 1'b0,
    GS_SWEEP = 1'b1
  } gen_state_e;

  // function mask code to compared devfn low bits
  function automatic logic [2:0] fm_to_mask(input logic [1:0] fm);
    logic [2:0] m;
    case (fm)
      2'd0:    m = 3'b000;
      2'd1:    m = 3'b100;
      2'd2:    m = 3'b110;
      default: m = 3'b111;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ctxc_gen_ctrl.sv
module ctxc_gen_ctrl
  import ctxc_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int GEN_W = 32,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_g,
  output logic [GEN_W-1:0] gen_q,
  output logic [GEN_W-1:0] gen_d,
  output logic             busy,
  output logic             sweep_clr,
  output logic [IDX_W-1:0] sweep_idx
);
  localparam logic [GEN_W-1:0] GEN_MAX = '1;
  localparam logic [GEN_W-1:0] GEN_ONE = GEN_W'(1);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(SLOTS - 1);

  gen_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    gen_d   = gen_q;
    idx_d   = idx_q;
    case (state_q)
      GS_RUN: begin
        if (inv_g) begin
          gen_d = gen_q + GEN_ONE;
          if (gen_d == GEN_MAX) begin
            state_d = GS_SWEEP;
            idx_d   = '0;
          end
        end
      end
      default: begin
        if (idx_q == LAST) begin
          gen_d   = GEN_ONE;
          state_d = GS_RUN;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_RUN;
      gen_q   <= GEN_ONE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      gen_q   <= gen_d;
      idx_q   <= idx_d;
    end
  end

  assign busy      = (state_q == GS_SWEEP);
  assign sweep_clr = busy;
  assign sweep_idx = idx_q;

  // R1: stamp value 0 is reserved for stale slots, never the live generation
  a_r1_gen_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    gen_q != '0);

  a_r4_gen_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && inv_g && gen_q != GEN_MAX - GEN_ONE) |=> gen_q == $past(gen_q) + GEN_ONE);

  a_r5_sweep_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && inv_g && gen_q == GEN_MAX - GEN_ONE) |=> busy && gen_q == GEN_MAX);

  a_r5_sweep_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> gen_q == GEN_ONE);
endmodule

// File: rtl/ctxc_match.sv
module ctxc_match
  import ctxc_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int GEN_W = 32
) (
  input  logic [SLOTS-1:0][SID_W-1:0] key_q,
  input  logic [SLOTS-1:0][GEN_W-1:0] tag_q,
  input  logic [GEN_W-1:0]            gen_q,
  input  logic [GEN_W-1:0]            gen_post,
  input  logic [SID_W-1:0]            lk_sid,
  input  logic [SID_W-1:0]            fill_sid,
  input  logic                        inv_d,
  input  logic [SID_W-1:0]            inv_sid,
  input  logic [1:0]                  inv_fm,
  output logic [SLOTS-1:0][GEN_W-1:0] tag_post,
  output logic [SLOTS-1:0]            lk_hit_vec,
  output logic [SLOTS-1:0]            fresh_vec,
  output logic [SLOTS-1:0]            fill_hit_vec
);
  logic [2:0]       dmask;
  logic [SLOTS-1:0] dev_sel;

  assign dmask = fm_to_mask(inv_fm);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign dev_sel[i] = (key_q[i][SID_W-1:BUS_LSB] == inv_sid[SID_W-1:BUS_LSB]) &&
                        (((key_q[i][2:0] ^ inv_sid[2:0]) & dmask) == 3'b000);
    assign tag_post[i]     = (inv_d && dev_sel[i]) ? '0 : tag_q[i];
    assign fresh_vec[i]    = (tag_q[i] == gen_q);
    assign fill_hit_vec[i] = fresh_vec[i] && (key_q[i] == fill_sid);
    assign lk_hit_vec[i]   = (tag_post[i] == gen_post) && (key_q[i] == lk_sid);
  end
endmodule

// File: rtl/ctxc_alloc.sv
module ctxc_alloc #(
  parameter int SLOTS = 16,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_fill,
  input  logic [SLOTS-1:0] fill_hit_vec,
  input  logic [SLOTS-1:0] fresh_vec,
  output logic [IDX_W-1:0] tgt_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic [IDX_W-1:0] rr_q, rr_d;
  logic             replace;

  assign replace = do_fill && !(|fill_hit_vec) && (&fresh_vec);

  always_comb begin
    tgt_idx = rr_q;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!fresh_vec[i]) tgt_idx = IDX_W'(i);
    end
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (fill_hit_vec[i]) tgt_idx = IDX_W'(i);
    end
  end

  always_comb begin
    rr_d = rr_q;
    if (replace) rr_d = (rr_q == LAST) ? '0 : rr_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  a_r9_keep_own_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (do_fill && |fill_hit_vec) |-> fill_hit_vec[tgt_idx]);

  a_r9_free_before_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (do_fill && !(&fresh_vec) && !(|fill_hit_vec)) |-> !fresh_vec[tgt_idx]);
endmodule

// File: rtl/ctx_gen_cache.sv
module ctx_gen_cache
  import ctxc_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int GEN_W   = 32,
  parameter int ENTRY_W = 128,
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_req,
  input  logic [15:0]        lk_sid,
  input  logic               fill_req,
  input  logic               fill_fault,
  input  logic [15:0]        fill_sid,
  input  logic [ENTRY_W-1:0] fill_entry,
  input  logic               inv_glb,
  input  logic               inv_dev,
  input  logic [15:0]        inv_sid,
  input  logic [1:0]         inv_fm,
  output logic               busy,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [ENTRY_W-1:0] rsp_entry
);
  logic [SLOTS-1:0][SID_W-1:0]   key_q;
  logic [SLOTS-1:0][GEN_W-1:0]   tag_q, tag_d, tag_post;
  logic [SLOTS-1:0][ENTRY_W-1:0] entry_q;
  logic [SLOTS-1:0]              lk_hit_vec, fresh_vec, fill_hit_vec;
  logic [GEN_W-1:0]              gen_q, gen_d;
  logic [IDX_W-1:0]              sweep_idx, tgt_idx;
  logic                          sweep_clr, accept, inv_g, inv_d, do_fill;
  logic                          rsp_valid_d, rsp_hit_d;
  logic [ENTRY_W-1:0]            rd_entry, rsp_entry_d;

  assign accept  = !busy;
  assign inv_g   = inv_glb && accept;
  assign inv_d   = inv_dev && accept;
  assign do_fill = fill_req && !fill_fault && accept && !inv_glb && !inv_dev;

  ctxc_gen_ctrl #(.SLOTS(SLOTS), .GEN_W(GEN_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .inv_g     (inv_g),
    .gen_q     (gen_q),
    .gen_d     (gen_d),
    .busy      (busy),
    .sweep_clr (sweep_clr),
    .sweep_idx (sweep_idx)
  );

  ctxc_match #(.SLOTS(SLOTS), .GEN_W(GEN_W)) u_match (
    .key_q        (key_q),
    .tag_q        (tag_q),
    .gen_q        (gen_q),
    .gen_post     (gen_d),
    .lk_sid       (lk_sid),
    .fill_sid     (fill_sid),
    .inv_d        (inv_d),
    .inv_sid      (inv_sid),
    .inv_fm       (inv_fm),
    .tag_post     (tag_post),
    .lk_hit_vec   (lk_hit_vec),
    .fresh_vec    (fresh_vec),
    .fill_hit_vec (fill_hit_vec)
  );

  ctxc_alloc #(.SLOTS(SLOTS)) u_alloc (
    .clk          (clk),
    .rst_n        (rst_n),
    .do_fill      (do_fill),
    .fill_hit_vec (fill_hit_vec),
    .fresh_vec    (fresh_vec),
    .tgt_idx      (tgt_idx)
  );

  // stamp next state: sweep clear, then fill stamp, else post-invalidation value
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      tag_d[i] = tag_post[i];
      if (sweep_clr && sweep_idx == IDX_W'(i))     tag_d[i] = '0;
      else if (do_fill && tgt_idx == IDX_W'(i))    tag_d[i] = gen_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= tag_d;
  end

  // payload storage: written only on an enabled fill, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (do_fill && tgt_idx == IDX_W'(i)) begin
        key_q[i]   <= fill_sid;
        entry_q[i] <= fill_entry;
      end
    end
  end

  always_comb begin
    rd_entry = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (lk_hit_vec[i]) rd_entry = rd_entry | entry_q[i];
    end
  end

  assign rsp_valid_d = lk_req && accept;
  assign rsp_hit_d   = rsp_valid_d && (|lk_hit_vec);
  assign rsp_entry_d = rsp_hit_d ? rd_entry : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_entry <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
      rsp_entry <= rsp_entry_d;
    end
  end

  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));

  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_entry == '0);

  a_r2_hit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  a_r3_fill_stamp: assert property (@(posedge clk) disable iff (!rst_n)
    do_fill |=> tag_q[$past(tgt_idx)] == $past(gen_q));

  a_r5_sweep_clears: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> tag_q[$past(sweep_idx)] == '0);

  a_r7_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rsp_valid);
endmodule

// File: tb/ctx_gen_cache_tb.sv
module ctx_gen_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 4;
  localparam int GW   = 3;
  localparam int EW   = 128;
  localparam int GMAX = (1 << GW) - 1;

  logic          clk, rst_n;
  logic          lk_req, fill_req, fill_fault, inv_glb, inv_dev;
  logic [15:0]   lk_sid, fill_sid, inv_sid;
  logic [1:0]    inv_fm;
  logic [EW-1:0] fill_entry;
  logic          busy, rsp_valid, rsp_hit;
  logic [EW-1:0] rsp_entry;

  ctx_gen_cache #(.SLOTS(NS), .GEN_W(GW), .ENTRY_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_sid(lk_sid),
    .fill_req(fill_req), .fill_fault(fill_fault), .fill_sid(fill_sid),
    .fill_entry(fill_entry), .inv_glb(inv_glb), .inv_dev(inv_dev),
    .inv_sid(inv_sid), .inv_fm(inv_fm), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_entry(rsp_entry)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // behavioural reference state
  logic [15:0]   mk [NS];
  int            mt [NS];
  logic [EW-1:0] me [NS];
  int            mgen, mrr, msidx;
  bit            mbusy;
  bit            e_valid, e_hit;
  logic [EW-1:0] e_ent;
  int            vecs, fails;
  string         req;

  function automatic logic [EW-1:0] ent(input int k);
    return {32'hC0DE0000 + k, 32'h1111 * k, ~(32'h0 + k), 32'h5A5A0000 + k};
  endfunction

  function automatic int fmask(input logic [1:0] fm);
    return (fm == 0) ? 0 : (fm == 1) ? 4 : (fm == 2) ? 6 : 7;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NS; i++) begin mt[i] = 0; mk[i] = '0; me[i] = '0; end
    mgen = 1; mrr = 0; msidx = 0; mbusy = 0;
    e_valid = 0; e_hit = 0; e_ent = '0;
  endtask

  task automatic model_step();
    int tp [NS];
    int gnew, tgt, m;
    e_valid = 0; e_hit = 0; e_ent = '0;
    if (mbusy) begin
      mt[msidx] = 0;
      if (msidx == NS - 1) begin mgen = 1; mbusy = 0; end
      else msidx++;
      return;
    end
    m = fmask(inv_fm);
    for (int i = 0; i < NS; i++) begin
      tp[i] = mt[i];
      if (inv_dev && mk[i][15:8] == inv_sid[15:8] &&
          ((int'(mk[i][2:0]) & m) == (int'(inv_sid[2:0]) & m))) tp[i] = 0;
    end
    gnew = inv_glb ? mgen + 1 : mgen;
    if (lk_req) begin
      e_valid = 1;
      for (int i = 0; i < NS; i++)
        if (tp[i] == gnew && mk[i] == lk_sid) begin e_hit = 1; e_ent = me[i]; end
    end
    if (fill_req && !fill_fault && !inv_glb && !inv_dev) begin
      tgt = -1;
      for (int i = 0; i < NS; i++)
        if (tgt < 0 && mt[i] == mgen && mk[i] == fill_sid) tgt = i;
      for (int i = 0; i < NS; i++)
        if (tgt < 0 && mt[i] != mgen) tgt = i;
      if (tgt < 0) begin tgt = mrr; mrr = (mrr + 1) % NS; end
      mk[tgt] = fill_sid; me[tgt] = fill_entry; tp[tgt] = mgen;
    end
    for (int i = 0; i < NS; i++) mt[i] = tp[i];
    mgen = gnew;
    if (mgen == GMAX) begin mbusy = 1; msidx = 0; end
  endtask

  task automatic clear_in();
    lk_req = 0; fill_req = 0; fill_fault = 0; inv_glb = 0; inv_dev = 0;
    lk_sid = '0; fill_sid = '0; inv_sid = '0; inv_fm = '0; fill_entry = '0;
  endtask

  // one clock: model the drive, wait for the edge, compare mid-cycle
  task automatic cyc();
    model_step();
    @(negedge clk);
    vecs++;
    if (busy !== mbusy || rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_entry !== e_ent) begin
      fails++;
      $display("FAIL %s: busy/valid/hit/entry got %0b/%0b/%0b/%h exp %0b/%0b/%0b/%h",
               req, busy, rsp_valid, rsp_hit, rsp_entry, mbusy, e_valid, e_hit, e_ent);
    end
    clear_in();
  endtask

  task automatic lookup(input logic [15:0] s);
    lk_req = 1; lk_sid = s; cyc();
  endtask

  task automatic fill(input logic [15:0] s, input int k);
    fill_req = 1; fill_sid = s; fill_entry = ent(k); cyc();
  endtask

  task automatic dev_inv(input logic [15:0] s, input logic [1:0] fm);
    inv_dev = 1; inv_sid = s; inv_fm = fm; cyc();
  endtask

  task automatic load_bus_set();
    fill(16'h1208, 1); fill(16'h120D, 2); fill(16'h120E, 3); fill(16'h3408, 4);
  endtask

  task automatic probe_bus_set();
    lookup(16'h1208); lookup(16'h120D); lookup(16'h120E); lookup(16'h3408);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    vecs = 0; fails = 0;
    clear_in();
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    req = "R1"; cyc(); lookup(16'h0000); lookup(16'h1208);

    req = "R3"; fill(16'h0102, 10); lookup(16'h0102);
    fill_fault = 1; fill(16'h0203, 11); lookup(16'h0203);
    req = "R2"; lookup(16'h0103); lookup(16'h0002);
    fill(16'h0102, 12); lookup(16'h0102);

    req = "R4"; inv_glb = 1; cyc(); lookup(16'h0102);
    fill(16'h0102, 13); lookup(16'h0102);

    req = "R6";
    load_bus_set(); dev_inv(16'h120C, 2'd1); probe_bus_set();
    load_bus_set(); dev_inv(16'h1204, 2'd2); probe_bus_set();
    load_bus_set(); dev_inv(16'h1216, 2'd3); probe_bus_set();
    load_bus_set(); dev_inv(16'h12FF, 2'd0); probe_bus_set();
    load_bus_set(); dev_inv(16'h5508, 2'd3); probe_bus_set();

    req = "R9";
    inv_glb = 1; cyc();
    fill(16'h0A00, 20); fill(16'h0A01, 21); fill(16'h0A02, 22); fill(16'h0A03, 23);
    fill(16'h0A01, 24); lookup(16'h0A01);
    fill(16'h0A04, 25); lookup(16'h0A00); lookup(16'h0A04);
    fill(16'h0A05, 26); lookup(16'h0A01); lookup(16'h0A05);
    dev_inv(16'h0A02, 2'd3); fill(16'h0A06, 27); lookup(16'h0A06); lookup(16'h0A03);

    req = "R8";
    fill(16'h0B00, 30); lookup(16'h0B00);
    lk_req = 1; lk_sid = 16'h0B00; inv_glb = 1; cyc(); lookup(16'h0B00);
    fill(16'h0B01, 31);
    lk_req = 1; lk_sid = 16'h0B01; inv_dev = 1; inv_sid = 16'h0B01; inv_fm = 2'd3; cyc();
    fill_req = 1; fill_sid = 16'h0B02; fill_entry = ent(32); inv_dev = 1; inv_sid = 16'h7700; cyc();
    lookup(16'h0B02);
    fill_req = 1; fill_sid = 16'h0B03; fill_entry = ent(33); inv_glb = 1; cyc();
    lookup(16'h0B03);

    req = "R5";
    while (mgen != GMAX - 1 && !mbusy) begin inv_glb = 1; cyc(); end
    fill(16'h0C00, 40); lookup(16'h0C00);
    lk_req = 1; lk_sid = 16'h0C00; inv_glb = 1; cyc();
    req = "R7";
    for (int i = 0; i < NS; i++) begin
      lk_req = 1; lk_sid = 16'h0C00; fill_req = 1; fill_sid = 16'h0C01;
      fill_entry = ent(41); inv_glb = (i == 1); cyc();
    end
    req = "R5"; cyc(); lookup(16'h0C00); lookup(16'h0C01);
    fill(16'h0C02, 42); lookup(16'h0C02);
    inv_glb = 1; cyc(); lookup(16'h0C02);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule